// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block receives asynchronous serial frames of ten bits: a low start bit, eight data bits with the least significant bit first, and a stop bit. The line is resynchronised to the core clock, then observed only on cycles where an external enable pulses at sixteen times the baud rate. A falling edge seen on an enabled cycle opens a frame and restarts a local phase counter with sixteen states. Each bit is decided by a two-out-of-three vote over three samples taken around its middle. A start bit that does not vote low is treated as noise, and the receiver goes back to watching for the next falling edge.

The receiver tracks its position in the frame without a bit counter. A nine-bit shift register is filled with ones when the frame opens. Each decided bit enters at the top and moves toward bit 0. When the start bit's zero arrives at bit 0, the next decision is the stop bit, which completes the frame. At completion the byte and the stop bit are copied into holding registers and a done flag is raised. This happens only if the flag is still clear, and, when the multiprocessor input is high, only if the stop bit is 1. Otherwise the frame is dropped. An external pulse clears the flag.

Top module: `serial_rx_vote`

## Requirements
- R1: After reset, rx_byte is 0x00, rx_stop is 0 and rx_done is 0, and the receiver waits for a falling edge.
- R2: A frame is a 0 start bit, eight data bits, then a stop bit. The first data bit received lands in rx_byte bit 0 and the eighth in bit 7.
- R3: Phase 0 is the enabled cycle that detects the falling edge. Each bit is sampled at phases 7, 8 and 9 and takes the majority value. One disagreeing sample leaves the bit unchanged. Two disagreeing samples invert it.
- R4: If the start bit votes 1, the frame is abandoned with no change to any output. A later falling edge starts a new frame normally.
- R5: A completed frame is loaded only while rx_done is 0. If rx_done is 1, rx_byte, rx_stop and rx_done keep their values.
- R6: If mp_mode is 1 and the stop bit votes 0, the frame is dropped with all outputs unchanged. If mp_mode is 1 and the stop bit is 1, the frame loads. If mp_mode is 0, the frame loads whatever the stop bit is.
- R7: rx_stop holds the voted stop bit of the last loaded frame.
- R8: A one-cycle pulse on done_clr drops rx_done to 0 and leaves rx_byte and rx_stop unchanged.
- R9: A start bit that follows a stop bit immediately, with no idle time, is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle pulse at sixteen times the baud rate |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| mp_mode | input | 1 | When high, a frame with a 0 stop bit is dropped |
| done_clr | input | 1 | Clears rx_done |
| rx_byte | output | 8 | Last loaded data byte |
| rx_stop | output | 1 | Stop bit of the last loaded frame |
| rx_done | output | 1 | Set when a frame loads, cleared by done_clr |

## Verification
The assertions assume three things about the inputs: sample_en is a single-cycle pulse, at most one per clock; rxd_in holds each level long enough for the synchroniser to pass it on; and done_clr is the only way rx_done falls. The stimulus keeps to these assumptions. It generates sample_en every fourth clock and changes the line only on a falling clock edge just after an enabled cycle. Each level therefore covers exactly one sample, and a glitch can be placed on a chosen phase. done_clr is pulsed for one cycle at a time, and mp_mode changes only between frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SRX_OSR    = 16;
    localparam int SRX_DATA_W = 8;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } srx_state_e;

    typedef struct packed {
        logic [SRX_DATA_W-1:0] data;
        logic                  stop;
    } srx_frame_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd_in,
    output logic rxd_sync,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= rxd_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], rxd_in};
            end
        end
    endgenerate

    assign rxd_sync = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)       last_q <= 1'b1;
        else if (tick) last_q <= rxd_sync;
    end

    assign fall = tick && last_q && !rxd_sync;

endmodule

// File: rtl/srx_voter.sv
module srx_voter import srx_pkg::*; #(
    parameter int PH_W       = 4,
    parameter int SAMPLE_MID = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            active,
    input  logic [PH_W-1:0] phase,
    input  logic            rxd_sync,
    output logic            decide,
    output logic            bit_val
);

    localparam logic [PH_W-1:0] PH_EARLY = PH_W'(SAMPLE_MID - 1);
    localparam logic [PH_W-1:0] PH_MID   = PH_W'(SAMPLE_MID);
    localparam logic [PH_W-1:0] PH_LATE  = PH_W'(SAMPLE_MID + 1);

    logic s_early_q;
    logic s_mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_early_q <= 1'b1;
            s_mid_q   <= 1'b1;
        end else if (tick && active) begin
            if (phase == PH_EARLY) s_early_q <= rxd_sync;
            if (phase == PH_MID)   s_mid_q   <= rxd_sync;
        end
    end

    assign decide  = tick && active && (phase == PH_LATE);
    assign bit_val = maj3(s_early_q, s_mid_q, rxd_sync);

    AST_UNANIMOUS_VOTE: assert property (@(posedge clk) disable iff (rst)
        (decide && (s_early_q == s_mid_q) && (s_mid_q == rxd_sync)) |-> (bit_val == rxd_sync)); // R3

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preload,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] sreg
);

    always_ff @(posedge clk) begin
        if (rst)          sreg <= '1;
        else if (preload) sreg <= '1;
        else if (shift)   sreg <= {din, sreg[WIDTH-1:1]};
    end

endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote import srx_pkg::*; #(
    parameter int OSR         = SRX_OSR,
    parameter int SAMPLE_MID  = OSR / 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_en,
    input  logic                  rxd_in,
    input  logic                  mp_mode,
    input  logic                  done_clr,
    output logic [SRX_DATA_W-1:0] rx_byte,
    output logic                  rx_stop,
    output logic                  rx_done
);

    localparam int              PH_W   = $clog2(OSR);
    localparam int              SR_W   = SRX_DATA_W + 1;
    localparam logic [PH_W-1:0] PH_TOP = PH_W'(OSR - 1);

    logic             rxd_sync;
    logic             fall;
    logic             decide;
    logic             bit_val;
    logic [SR_W-1:0]  sreg;
    srx_state_e       state_q;
    logic [PH_W-1:0]  phase_q;
    srx_frame_t       held_q;
    logic             done_q;

    logic first_bit;
    logic last_bit;
    logic start_bad;
    logic frame_end;
    logic sr_load;
    logic sr_shift;
    logic accept;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_en),
        .rxd_in   (rxd_in),
        .rxd_sync (rxd_sync),
        .fall     (fall)
    );

    srx_voter #(.PH_W(PH_W), .SAMPLE_MID(SAMPLE_MID)) u_vote (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_en),
        .active   (state_q == RX_BUSY),
        .phase    (phase_q),
        .rxd_sync (rxd_sync),
        .decide   (decide),
        .bit_val  (bit_val)
    );

    srx_shifter #(.WIDTH(SR_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .preload (sr_load),
        .shift   (sr_shift),
        .din     (bit_val),
        .sreg    (sreg)
    );

    // An all-ones register means nothing has been shifted in yet (first decision is the start bit);
    // a zero at bit 0 means the start bit has travelled through, so this decision is the stop bit.
    always_comb begin
        first_bit = (sreg == '1);
        last_bit  = !sreg[0];
        start_bad = decide && first_bit && bit_val;
        frame_end = decide && last_bit;
        sr_load   = (state_q == RX_IDLE) && fall;
        sr_shift  = decide && !start_bad;
        accept    = frame_end && !done_q && (!mp_mode || bit_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            phase_q <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (fall) begin
                        state_q <= RX_BUSY;
                        phase_q <= PH_W'(1);
                    end
                end
                RX_BUSY: begin
                    if (start_bad || frame_end) begin
                        state_q <= RX_IDLE;
                        phase_q <= '0;
                    end else if (sample_en) begin
                        phase_q <= (phase_q == PH_TOP) ? '0 : phase_q + PH_W'(1);
                    end
                end
                default: begin
                    state_q <= RX_IDLE;
                    phase_q <= '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            held_q.data <= sreg[SR_W-1:1];
            held_q.stop <= bit_val;
            done_q      <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    assign rx_byte = held_q.data;
    assign rx_stop = held_q.stop;
    assign rx_done = done_q;

    AST_LOAD_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(state_q == RX_BUSY)); // R2

    AST_HOLD_WHILE_DONE: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !done_clr) |=> ($stable(rx_byte) && $stable(rx_stop) && rx_done)); // R5

    AST_MP_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_done) && $past(mp_mode)) |-> rx_stop); // R6

    AST_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
        (rx_done && done_clr) |=> !rx_done); // R8

endmodule

// File: tb/sim_serial_rx_vote.sv
module sim_serial_rx_vote;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_en = 1'b0;
    logic       rxd_in = 1'b1;
    logic       mp_mode = 1'b0;
    logic       done_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_done;

    int n_run  = 0;
    int n_fail = 0;
    int ticks  = 0;
    logic [1:0] div_q = '0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        div_q     <= div_q + 2'd1;
        sample_en <= (div_q == 2'd2);
        if (sample_en) ticks <= ticks + 1;
    end

    serial_rx_vote u0 (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .rxd_in    (rxd_in),
        .mp_mode   (mp_mode),
        .done_clr  (done_clr),
        .rx_byte   (rx_byte),
        .rx_stop   (rx_stop),
        .rx_done   (rx_done)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        int c0 = ticks;
        while (ticks == c0) @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input logic [15:0] flips);
        for (int j = 0; j < 16; j++) begin
            rxd_in = v ^ flips[j];
            wait_tick();
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic sb, input int fbit, input logic [15:0] fmask);
        for (int k = 0; k < 10; k++) begin
            logic v;
            v = (k == 0) ? 1'b0 : (k == 9) ? sb : d[k-1];
            send_bit(v, (k == fbit) ? fmask : 16'h0);
        end
    endtask

    task automatic idle_bit();
        send_bit(1'b1, 16'h0);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "byte after reset", {8'h0, rx_byte}, 16'h00);
        chk("R1", "stop after reset", {15'h0, rx_stop}, 16'h0);
        chk("R1", "done after reset", {15'h0, rx_done}, 16'h0);
    endtask

    task automatic t_basic();
        wait_tick();
        send_frame(8'hA5, 1'b1, -1, 16'h0);
        idle_bit();
        chk("R2", "byte A5", {8'h0, rx_byte}, 16'h00A5);
        chk("R7", "stop of A5", {15'h0, rx_stop}, 16'h1);
        chk("R2", "done after A5", {15'h0, rx_done}, 16'h1);
    endtask

    task automatic t_clear();
        pulse_clr();
        @(negedge clk);
        chk("R8", "done after clear", {15'h0, rx_done}, 16'h0);
        chk("R8", "byte kept by clear", {8'h0, rx_byte}, 16'h00A5);
        chk("R8", "stop kept by clear", {15'h0, rx_stop}, 16'h1);
    endtask

    task automatic t_full_discard();
        wait_tick();
        send_frame(8'h11, 1'b1, -1, 16'h0);
        idle_bit();
        pulse_clr();
        wait_tick();
        send_frame(8'h22, 1'b1, -1, 16'h0);
        idle_bit();
        chk("R5", "first byte loaded", {8'h0, rx_byte}, 16'h0022);
        wait_tick();
        send_frame(8'h77, 1'b0, -1, 16'h0);
        idle_bit();
        chk("R5", "byte kept while done", {8'h0, rx_byte}, 16'h0022);
        chk("R5", "stop kept while done", {15'h0, rx_stop}, 16'h1);
        chk("R5", "done still set", {15'h0, rx_done}, 16'h1);
        pulse_clr();
    endtask

    task automatic t_mp();
        mp_mode = 1'b1;
        wait_tick();
        send_frame(8'h3C, 1'b0, -1, 16'h0);
        idle_bit();
        chk("R6", "mp drop keeps done low", {15'h0, rx_done}, 16'h0);
        chk("R6", "mp drop keeps byte", {8'h0, rx_byte}, 16'h0022);
        send_frame(8'h81, 1'b1, -1, 16'h0);
        idle_bit();
        chk("R6", "mp stop1 byte", {8'h0, rx_byte}, 16'h0081);
        chk("R6", "mp stop1 done", {15'h0, rx_done}, 16'h1);
        pulse_clr();
        mp_mode = 1'b0;
        wait_tick();
        send_frame(8'h00, 1'b0, -1, 16'h0);
        idle_bit();
        chk("R6", "plain stop0 byte", {8'h0, rx_byte}, 16'h0000);
        chk("R7", "plain stop0 stop", {15'h0, rx_stop}, 16'h0);
        chk("R6", "plain stop0 done", {15'h0, rx_done}, 16'h1);
        pulse_clr();
    endtask

    task automatic t_false_start();
        wait_tick();
        send_bit(1'b0, 16'hFFF8);
        idle_bit();
        idle_bit();
        chk("R4", "glitch leaves done", {15'h0, rx_done}, 16'h0);
        chk("R4", "glitch leaves byte", {8'h0, rx_byte}, 16'h0000);
        chk("R4", "glitch leaves stop", {15'h0, rx_stop}, 16'h0);
        send_frame(8'h5A, 1'b1, -1, 16'h0);
        idle_bit();
        chk("R4", "frame after glitch", {8'h0, rx_byte}, 16'h005A);
        pulse_clr();
    endtask

    task automatic t_noise();
        wait_tick();
        send_frame(8'hF0, 1'b1, 4, 16'h0100);
        idle_bit();
        chk("R3", "one bad sample at 8", {8'h0, rx_byte}, 16'h00F0);
        pulse_clr();
        wait_tick();
        send_frame(8'h0F, 1'b1, 2, 16'h0200);
        idle_bit();
        chk("R3", "one bad sample at 9", {8'h0, rx_byte}, 16'h000F);
        pulse_clr();
        wait_tick();
        send_frame(8'h00, 1'b1, 3, 16'h0180);
        idle_bit();
        chk("R3", "two bad samples flip d2", {8'h0, rx_byte}, 16'h0004);
        pulse_clr();
        wait_tick();
        send_frame(8'hC3, 1'b1, 0, 16'h0080);
        idle_bit();
        chk("R3", "noisy start accepted", {8'h0, rx_byte}, 16'h00C3);
        pulse_clr();
    endtask

    task automatic t_back_to_back();
        wait_tick();
        send_frame(8'h96, 1'b1, -1, 16'h0);
        fork
            send_frame(8'h69, 1'b1, -1, 16'h0);
            begin
                repeat (20) wait_tick();
                chk("R9", "first of pair", {8'h0, rx_byte}, 16'h0096);
                pulse_clr();
            end
        join
        idle_bit();
        chk("R9", "second of pair", {8'h0, rx_byte}, 16'h0069);
        chk("R9", "second done", {15'h0, rx_done}, 16'h1);
        pulse_clr();
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_full_discard();
        t_mp();
        t_false_start();
        t_noise();
        t_back_to_back();
        report();
    end

endmodule